// File: doc/BRIEF.md
# Predicated Outer-Product Accumulate Engine

This block adds the outer product of two half-precision source vectors into a square accumulator tile kept in local storage. The vector length `VL` is a parameter. With 16-bit elements the tile is `dim`×`dim`, where `dim = VL/16`, and the storage holds two such tiles. A caller presents both vectors, one mask per vector, and a tile number, then pulses `start`. The engine captures these operands and steps a single fused multiply-add datapath across the selected tile in row-major order, one element per cycle. It then reports completion with a one-cycle `done` pulse.

Each mask has one bit per vector byte. Element `k` is governed by mask bit `2k`, and the odd bits play no part. A tile element is updated only when both its row element in the first vector and its column element in the second vector are active. Every other element keeps its old bits exactly. The arithmetic is a true fused multiply-add: the exact value `acc + a*b` is rounded once to nearest-even. Every NaN result is replaced by the single quiet pattern 16'h7E00. When the engine is idle, tile contents can be read back through a combinational port.

Top module: `opa_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and every element of every tile reads back as 16'h0000.
- R2: The element at row r, column c of tile t is read back at `rd_tile`=t, `rd_idx`=r*dim+c. Row r uses element r of `vec_a` (bits 16r+15:16r), and column c uses element c of `vec_b`.
- R3: When both governing bits are set, the element becomes the fused sum acc + a[r]*b[c], rounded once to nearest-even. Results below 2^-14 are gradual (subnormal) values.
- R4: When either governing bit is clear, the element keeps its previous 16 bits unchanged.
- R5: Row r is governed by `mask_a` bit 2r and column c by `mask_b` bit 2c. Odd mask bits have no effect.
- R6: Only the tile named by `tile_sel` at the accepted start changes. The other tile is left untouched.
- R7: A start accepted at clock edge E0 raises `busy` from E0. `done` is 1 for exactly the one cycle that follows edge E0+dim*dim+1, and `busy` falls at that same edge.
- R8: A `start` pulse seen while `busy` is 1 is ignored. It changes neither the timing nor the results of the operation in progress.
- R9: A NaN operand, an infinity times zero, or a sum of opposite infinities gives 16'h7E00.
- R10: A finite result whose magnitude rounds to 65520 or more gives a signed infinity (x7C00). An exact zero from operands of opposite sign gives +0. A product of zeros added to a zero of the same sign keeps that sign.
- R11: Vectors, masks and tile number are sampled at the accepted start. Changing them while `busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an accumulate operation (taken only when idle) |
| tile_sel | input | 1 | Destination tile number (log2(ESIZE/8) bits) |
| vec_a | input | VL | Row source vector, dim half-precision elements |
| vec_b | input | VL | Column source vector, dim half-precision elements |
| mask_a | input | VL/8 | Row governing mask, one bit per byte |
| mask_b | input | VL/8 | Column governing mask, one bit per byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_tile | input | 1 | Readback tile number |
| rd_idx | input | log2(dim*dim) | Readback element index r*dim+c |
| rd_data | output | 16 | Readback element value (valid while idle) |

## Verification
The bench builds the engine at its default `VL`=128. This gives an 8×8 tile of 64 elements, two tiles and 16-bit masks. Eight lanes per vector let one operation cover NaN, infinity, zero, the largest finite value, subnormals and ordinary numbers as rows and columns in every combination. A second pass with the column signs flipped then drives exact cancellations and opposite infinities. The 64-cycle sweep is long enough to inject a second start and to change every input in the middle of a run.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam int ESIZE    = 16;
  localparam int MAN_W    = 10;
  localparam int FIXW     = 82;   // exact fixed-point window, LSB = 2^-48
  localparam int LEADW    = 7;
  localparam int NORM_LEAD = 34;  // leading-one position of 2^-14
  localparam int SUB_LSB  = 24;   // position of 2^-24, the subnormal quantum
  localparam int PROD_BIAS = 2;   // product shift = ea + eb - PROD_BIAS
  localparam int ADD_BIAS  = 23;  // addend shift  = ec + ADD_BIAS

  localparam logic [15:0] QNAN    = 16'h7E00;
  localparam logic [14:0] INF_MAG = 15'h7C00;

  typedef struct packed {
    logic       sign;
    logic [4:0] exp;
    logic [9:0] man;
  } half_t;

  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_zero;
  } hcls_t;

  function automatic hcls_t classify(input half_t h);
    hcls_t c;
    c.is_nan  = (h.exp == 5'h1F) && (h.man != '0);
    c.is_inf  = (h.exp == 5'h1F) && (h.man == '0);
    c.is_zero = (h.exp == 5'h00) && (h.man == '0);
    return c;
  endfunction
endpackage

// File: rtl/opa_seq.sv
module opa_seq #(
  parameter int ELEMS = 64,
  localparam int CW   = $clog2(ELEMS + 1),
  localparam int IDXW = $clog2(ELEMS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            accept,
  output logic            busy,
  output logic            done,
  output logic            iss_vld,
  output logic [IDXW-1:0] iss_idx
);
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    accept = start && !busy_q;
    last   = busy_q && (cnt_q == CW'(ELEMS));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign iss_vld = busy_q && (cnt_q < CW'(ELEMS));
  assign iss_idx = cnt_q[IDXW-1:0];

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && (cnt_q == $past(cnt_q) + CW'(1))));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/opa_align_add.sv
module opa_align_add
  import opa_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [AW-1:0]   in_addr,
  input  logic [15:0]     op_a,
  input  logic [15:0]     op_b,
  input  logic [15:0]     op_c,
  output logic            s1_vld,
  output logic [AW-1:0]   s1_addr,
  output logic            s1_spec,
  output logic [15:0]     s1_spec_val,
  output logic            s1_sign,
  output logic            s1_zsign,
  output logic [FIXW-1:0] s1_mag
);
  half_t ha, hb, hc;
  hcls_t ca, cb, cc;
  logic [10:0] ma, mb, mc;
  logic [4:0]  eea, eeb, eec;
  logic [21:0] prod;
  logic [5:0]  psh, csh;
  logic [FIXW-1:0] pfix, cfix;
  logic        sp, p_inf;
  logic        spec_d, sign_d, zsign_d;
  logic [15:0] spec_val_d;
  logic [FIXW-1:0] mag_d;

  always_comb begin
    ha = half_t'(op_a);
    hb = half_t'(op_b);
    hc = half_t'(op_c);
    ca = classify(ha);
    cb = classify(hb);
    cc = classify(hc);
    ma  = {(ha.exp != '0), ha.man};
    mb  = {(hb.exp != '0), hb.man};
    mc  = {(hc.exp != '0), hc.man};
    eea = (ha.exp == '0) ? 5'd1 : ha.exp;
    eeb = (hb.exp == '0) ? 5'd1 : hb.exp;
    eec = (hc.exp == '0) ? 5'd1 : hc.exp;
    prod = 22'(ma) * 22'(mb);
    psh  = 6'(eea) + 6'(eeb) - 6'(PROD_BIAS);
    csh  = 6'(eec) + 6'(ADD_BIAS);
    pfix = FIXW'(prod) << psh;
    cfix = FIXW'(mc) << csh;
    sp    = ha.sign ^ hb.sign;
    p_inf = ca.is_inf || cb.is_inf;
  end

  // special operands
  always_comb begin
    spec_d     = 1'b1;
    spec_val_d = QNAN;
    if (ca.is_nan || cb.is_nan || cc.is_nan) begin
      spec_val_d = QNAN;
    end else if (p_inf && (ca.is_zero || cb.is_zero)) begin
      spec_val_d = QNAN;
    end else if (p_inf && cc.is_inf && (sp != hc.sign)) begin
      spec_val_d = QNAN;
    end else if (p_inf) begin
      spec_val_d = {sp, INF_MAG};
    end else if (cc.is_inf) begin
      spec_val_d = op_c;
    end else begin
      spec_d = 1'b0;
    end
  end

  // exact signed-magnitude sum
  always_comb begin
    zsign_d = sp & hc.sign;
    if (sp == hc.sign) begin
      mag_d  = pfix + cfix;
      sign_d = sp;
    end else if (pfix >= cfix) begin
      mag_d  = pfix - cfix;
      sign_d = sp;
    end else begin
      mag_d  = cfix - pfix;
      sign_d = hc.sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_addr     <= in_addr;
      s1_spec     <= spec_d;
      s1_spec_val <= spec_val_d;
      s1_sign     <= sign_d;
      s1_zsign    <= zsign_d;
      s1_mag      <= mag_d;
    end
  end
endmodule

// File: rtl/opa_round.sv
module opa_round
  import opa_pkg::*;
(
  input  logic            spec,
  input  logic [15:0]     spec_val,
  input  logic            sign,
  input  logic            zsign,
  input  logic [FIXW-1:0] mag,
  output logic [15:0]     res
);
  logic [LEADW-1:0] lead, lsb, gpos;
  logic [FIXW-1:0]  shifted, sticky_mask;
  logic [11:0]      kept;
  logic             guard, sticky, rup;
  logic [12:0]      rnd;
  logic [16:0]      base, sum;
  logic             normal;

  always_comb begin
    lead = '0;
    for (int i = 0; i < FIXW; i++) begin
      if (mag[i]) lead = LEADW'(i);
    end
  end

  always_comb begin
    normal      = (lead >= LEADW'(NORM_LEAD));
    lsb         = normal ? (lead - LEADW'(MAN_W)) : LEADW'(SUB_LSB);
    gpos        = lsb - LEADW'(1);
    shifted     = mag >> lsb;
    kept        = shifted[11:0];
    guard       = mag[gpos];
    sticky_mask = (FIXW'(1) << gpos) - FIXW'(1);
    sticky      = |(mag & sticky_mask);
    rup         = guard && (sticky || kept[0]);
    rnd         = 13'(kept) + 13'(rup);
    base        = normal ? ((17'(lead) - 17'(NORM_LEAD)) << MAN_W) : '0;
    sum         = base + 17'(rnd);
    if (spec)                       res = spec_val;
    else if (mag == '0)             res = {zsign, 15'h0000};
    else if (sum >= 17'(INF_MAG))   res = {sign, INF_MAG};
    else                            res = {sign, sum[14:0]};
  end

  always_comb begin
    // R9
    if (res[14:10] == 5'h1F && res[9:0] != '0)
      nan_canon_chk: assert (res == QNAN);
  end
endmodule

// File: rtl/opa_tile_store.sv
module opa_tile_store #(
  parameter int DEPTH = 128,
  parameter int EW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr_eng,
  output logic [EW-1:0] rdata_eng,
  input  logic [AW-1:0] raddr_rb,
  output logic [EW-1:0] rdata_rb
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_eng = mem[raddr_eng];
  assign rdata_rb  = mem[raddr_rb];
endmodule

// File: rtl/opa_engine.sv
module opa_engine
  import opa_pkg::*;
#(
  parameter int VL = 128,
  localparam int DIM       = VL / ESIZE,
  localparam int NUM_TILES = ESIZE / 8,
  localparam int BPE       = ESIZE / 8,
  localparam int TW        = $clog2(NUM_TILES),
  localparam int ELEMS     = DIM * DIM,
  localparam int IDXW      = $clog2(ELEMS),
  localparam int LDIM      = $clog2(DIM),
  localparam int MW        = VL / 8,
  localparam int DEPTH     = NUM_TILES * ELEMS,
  localparam int AW        = TW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TW-1:0]   tile_sel,
  input  logic [VL-1:0]   vec_a,
  input  logic [VL-1:0]   vec_b,
  input  logic [MW-1:0]   mask_a,
  input  logic [MW-1:0]   mask_b,
  output logic            busy,
  output logic            done,
  input  logic [TW-1:0]   rd_tile,
  input  logic [IDXW-1:0] rd_idx,
  output logic [ESIZE-1:0] rd_data
);
  logic            accept, iss_vld;
  logic [IDXW-1:0] iss_idx;
  logic [VL-1:0]   va_q, vb_q;
  logic [MW-1:0]   ma_q, mb_q;
  logic [TW-1:0]   tile_q;
  logic [LDIM-1:0] row, col;
  logic [ESIZE-1:0] a_el, b_el, acc_el;
  logic            act;
  logic [AW-1:0]   eng_addr;

  logic            s1_vld, s1_spec, s1_sign, s1_zsign;
  logic [AW-1:0]   s1_addr;
  logic [15:0]     s1_spec_val, wr_data;
  logic [FIXW-1:0] s1_mag;

  opa_seq #(.ELEMS(ELEMS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .busy    (busy),
    .done    (done),
    .iss_vld (iss_vld),
    .iss_idx (iss_idx)
  );

  // operand capture at accepted start
  always_ff @(posedge clk) begin
    if (accept) begin
      va_q   <= vec_a;
      vb_q   <= vec_b;
      ma_q   <= mask_a;
      mb_q   <= mask_b;
      tile_q <= tile_sel;
    end
  end

  always_comb begin
    row      = iss_idx[IDXW-1:LDIM];
    col      = iss_idx[LDIM-1:0];
    a_el     = va_q[int'(row)*ESIZE +: ESIZE];
    b_el     = vb_q[int'(col)*ESIZE +: ESIZE];
    act      = ma_q[int'(row)*BPE] && mb_q[int'(col)*BPE];
    eng_addr = {tile_q, iss_idx};
  end

  opa_align_add #(.AW(AW)) u_s1 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (iss_vld && act),
    .in_addr     (eng_addr),
    .op_a        (a_el),
    .op_b        (b_el),
    .op_c        (acc_el),
    .s1_vld      (s1_vld),
    .s1_addr     (s1_addr),
    .s1_spec     (s1_spec),
    .s1_spec_val (s1_spec_val),
    .s1_sign     (s1_sign),
    .s1_zsign    (s1_zsign),
    .s1_mag      (s1_mag)
  );

  opa_round u_s2 (
    .spec     (s1_spec),
    .spec_val (s1_spec_val),
    .sign     (s1_sign),
    .zsign    (s1_zsign),
    .mag      (s1_mag),
    .res      (wr_data)
  );

  opa_tile_store #(.DEPTH(DEPTH), .EW(ESIZE)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (s1_vld),
    .waddr     (s1_addr),
    .wdata     (wr_data),
    .raddr_eng (eng_addr),
    .rdata_eng (acc_el),
    .raddr_rb  ({rd_tile, rd_idx}),
    .rdata_rb  (rd_data)
  );

  // R7
  write_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> busy);
  // R6
  write_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_addr[AW-1:IDXW] == tile_q));
endmodule

// File: tb/opa_engine_tb.sv
`timescale 1ns/1ps
module opa_engine_tb;
  localparam int VL = 128;
  localparam int DIM = 8;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic tile_sel;
  logic [VL-1:0] vec_a, vec_b;
  logic [15:0] mask_a, mask_b;
  logic busy, done;
  logic rd_tile;
  logic [5:0] rd_idx;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  logic [15:0] mdl [2][N];

  always #4 clk = ~clk;

  opa_engine #(.VL(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tile_sel(tile_sel),
    .vec_a(vec_a), .vec_b(vec_b), .mask_a(mask_a), .mask_b(mask_b),
    .busy(busy), .done(done), .rd_tile(rd_tile), .rd_idx(rd_idx),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real h2r(input logic [15:0] h);
    real v;
    if (h[14:10] == 5'd0) v = real'(int'(h[9:0])) * pow2(-24);
    else v = real'(1024 + int'(h[9:0])) * pow2(int'(h[14:10]) - 25);
    return h[15] ? -v : v;
  endfunction

  function automatic logic [15:0] r2h(input real x);
    logic s = (x < 0.0);
    real ax = s ? -x : x;
    real q, m, fl;
    int e, n, bits;
    bit nrm;
    if (ax >= 65520.0) return {s, 15'h7C00};
    nrm = (ax >= pow2(-14));
    e = -14;
    if (nrm) begin
      for (int k = 15; k >= -14; k--) if (ax >= pow2(k)) begin e = k; break; end
      q = pow2(e - 10);
    end else q = pow2(-24);
    m = ax / q;
    fl = $floor(m);
    n = $rtoi(fl);
    if ((m - fl) > 0.5 || ((m - fl) == 0.5 && (n % 2) == 1)) n++;
    bits = nrm ? (e + 14) * 1024 + n : n;
    return {s, 15'(bits)};
  endfunction

  function automatic bit is_nan(input logic [15:0] h);
    return h[14:10] == 5'h1F && h[9:0] != 0;
  endfunction
  function automatic bit is_inf(input logic [15:0] h);
    return h[14:10] == 5'h1F && h[9:0] == 0;
  endfunction
  function automatic bit is_zero(input logic [15:0] h);
    return h[14:0] == 0;
  endfunction

  // R3 R9 R10 reference: specials first, else exact sum rounded once
  function automatic logic [15:0] fma_model(input logic [15:0] a, b, c);
    logic sp = a[15] ^ b[15];
    bit pinf = is_inf(a) || is_inf(b);
    real x;
    if (is_nan(a) || is_nan(b) || is_nan(c)) return 16'h7E00;
    if (pinf && (is_zero(a) || is_zero(b))) return 16'h7E00;
    if (pinf && is_inf(c) && sp != c[15]) return 16'h7E00;
    if (pinf) return {sp, 15'h7C00};
    if (is_inf(c)) return c;
    x = h2r(a) * h2r(b) + h2r(c);
    if (x == 0.0)
      return ((is_zero(a) || is_zero(b)) && is_zero(c) && sp && c[15]) ? 16'h8000 : 16'h0000;
    return r2h(x);
  endfunction

  function automatic logic [15:0] rand_half();
    logic [15:0] h;
    h[15] = 1'($urandom % 2);
    h[14:10] = 5'(10 + $urandom % 11);
    h[9:0] = 10'($urandom % 1024);
    return h;
  endfunction

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < DIM; i++) v[i*16 +: 16] = rand_half();
    return v;
  endfunction

  task automatic rb(input int t, input int idx, output logic [15:0] v);
    rd_tile = t[0];
    rd_idx = idx[5:0];
    #1;
    v = rd_data;
  endtask

  task automatic compare_all(input string what);
    logic [15:0] v;
    for (int t = 0; t < 2; t++) begin
      bit ok = 1;
      int bad_i = 0;
      logic [15:0] bad_a = 0, bad_e = 0;
      for (int i = 0; i < N; i++) begin
        rb(t, i, v);
        if (ok && v !== mdl[t][i]) begin
          ok = 0; bad_i = i; bad_a = v; bad_e = mdl[t][i];
        end
      end
      chk(ok, "R3 R4 R6", $sformatf("%s tile %0d elem %0d", what, t, bad_i), bad_a, bad_e);
    end
  endtask

  // runs one operation; interfere injects a start and new inputs mid-run (R8, R11)
  task automatic run_op(input int t, input logic [VL-1:0] a, b,
                        input logic [15:0] ma, mb, input bit interfere,
                        input string what);
    bit tim_ok = 1;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        if (ma[2*r] && mb[2*c])
          mdl[t][r*DIM+c] = fma_model(a[r*16 +: 16], b[c*16 +: 16], mdl[t][r*DIM+c]);
    tile_sel = t[0]; vec_a = a; vec_b = b; mask_a = ma; mask_b = mb;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7", {what, " busy after start"}, busy, 1);
    for (int i = 1; i <= N + 1; i++) begin
      if (interfere && i == 10) begin
        start = 1'b1; tile_sel = ~t[0]; vec_a = ~a; vec_b = rand_vec();
        mask_a = 16'hFFFF; mask_b = 16'hFFFF;
      end
      if (interfere && i == 11) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (done !== (i == N + 1) || busy !== (i <= N)) tim_ok = 0;
    end
    chk(tim_ok, "R7 R8", {what, " done/busy timing"}, {busy, done}, 2'b01);
    @(negedge clk);
    chk(done === 1'b0, "R7", {what, " done single pulse"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin : main
    logic [VL-1:0] sa, sb, nb, ones;
    logic [15:0] v;
    bit zok;
    void'($urandom(32'h5EED_0A11));
    rst_n = 1'b0; start = 1'b0; tile_sel = 1'b0;
    vec_a = '0; vec_b = '0; mask_a = '0; mask_b = '0; rd_tile = 1'b0; rd_idx = '0;
    for (int t = 0; t < 2; t++) for (int i = 0; i < N; i++) mdl[t][i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", {busy, done}, 0);
    zok = 1;
    for (int t = 0; t < 2; t++) for (int i = 0; i < N; i++) begin
      rb(t, i, v); if (v !== 16'h0000) zok = 0;
    end
    chk(zok, "R1", "tiles zero after reset", zok, 1);

    // R2 R5: single element via even mask bits, odd bits set as noise
    for (int i = 0; i < DIM; i++) begin ones[i*16 +: 16] = 16'h3C00; end
    run_op(1, ones, ones, 16'h0010 | 16'hAAAA, 16'h0400 | 16'hAAAA, 0, "layout");
    rb(1, 2*DIM+5, v);
    chk(v === 16'h3C00, "R2", "element (2,5) at index 21", v, 16'h3C00);
    rb(1, 2*DIM+4, v);
    chk(v === 16'h0000, "R5", "neighbour (2,4) untouched", v, 16'h0000);
    compare_all("layout");

    // R9 R10 special values onto a zero tile
    sa = {16'h0001, 16'hC100, 16'h3C00, 16'h0400, 16'h7BFF, 16'h0000, 16'h7C00, 16'h7D00};
    sb = {16'h0001, 16'hBC00, 16'h3555, 16'h0000, 16'hFC00, 16'h3800, 16'h4000, 16'h3C00};
    run_op(0, sa, sb, 16'hFFFF, 16'hFFFF, 0, "specials");
    rb(0, 0*DIM+0, v); chk(v === 16'h7E00, "R9", "NaN operand", v, 16'h7E00);
    rb(0, 1*DIM+4, v); chk(v === 16'h7E00, "R9", "inf times zero", v, 16'h7E00);
    rb(0, 1*DIM+3, v); chk(v === 16'hFC00, "R10", "inf times -inf", v, 16'hFC00);
    rb(0, 3*DIM+1, v); chk(v === 16'h7C00, "R10", "overflow to inf", v, 16'h7C00);
    rb(0, 4*DIM+2, v); chk(v === 16'h0200, "R3", "subnormal result", v, 16'h0200);
    rb(0, 7*DIM+7, v); chk(v === 16'h0000, "R3", "tiny rounds to +0", v, 16'h0000);
    compare_all("specials");

    // R9 R10 flipped column signs: cancellation and opposite infinities
    nb = sb;
    for (int i = 0; i < DIM; i++) nb[i*16+15] = ~sb[i*16+15];
    run_op(0, sa, nb, 16'hFFFF, 16'hFFFF, 0, "cancel");
    rb(0, 5*DIM+0, v); chk(v === 16'h0000, "R10", "exact cancel gives +0", v, 16'h0000);
    rb(0, 1*DIM+0, v); chk(v === 16'h7E00, "R9", "inf minus inf", v, 16'h7E00);
    rb(0, 2*DIM+4, v); chk(v === 16'h0000, "R10", "+0 plus -0 product", v, 16'h0000);
    compare_all("cancel");

    // R3 all active random
    for (int k = 0; k < 2; k++) begin
      run_op(1, rand_vec(), rand_vec(), 16'hFFFF, 16'hFFFF, 0, "dense");
      compare_all("dense");
    end

    // R4 R5 inactive: odd bits only, then one empty mask
    run_op(1, rand_vec(), rand_vec(), 16'hAAAA, 16'hAAAA, 0, "odd-only");
    compare_all("odd-only");
    run_op(1, rand_vec(), rand_vec(), 16'h0000, 16'hFFFF, 0, "empty");
    compare_all("empty");

    // R4 sparse random masks
    for (int k = 0; k < 3; k++) begin
      run_op(k % 2, rand_vec(), rand_vec(), 16'($urandom), 16'($urandom), 0, "sparse");
      compare_all("sparse");
    end

    // R8 R11 second start and changing inputs during a run
    run_op(1, rand_vec(), rand_vec(), 16'h5555, 16'h1F1F, 1, "interfere");
    compare_all("R8 R11 interfere");

    run_op(0, rand_vec(), rand_vec(), 16'hFFFF, 16'hFFFF, 0, "final");
    compare_all("final");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule